// File: doc/BRIEF.md
# Disk Controller Reset and Interface Personality Unit

This unit sits beside the core of a floppy-style disk controller and decides two things: when the core, its drive status and its FIFO are held in reset, and which interface personality the controller shows to the system. There are three reset sources. A synchronous hardware reset clears every register of the unit. A sticky reset bit in the digital output register stays set until the host writes it clear. A reset request from the data-rate register clears itself after a fixed number of cycles. When the sticky bit and the self-clearing request meet, the sticky bit wins.

Two configuration fields, an identity select and a recording-format select, pick one of three personalities: AT, PS/2 and Model 30. The personality decides whether the DMA-enable bit of the output register gates the output enables of the IRQ and DRQ pads. It also sets the polarity of the incoming terminal-count pin and of the outgoing density-select pin. The Specify parameters live in a register that only the Specify command writes, and no reset touches it.

Top module: `dskc_rst_mode`

## Requirements
- R1: While `rst` is high at a clock edge, the unit clears the configuration (Model 30 personality, `mode` = 0) and the DMA-enable bit, cancels any pending self-clearing reset and sets the sticky reset bit. After reset is released, `core_rst` = 1, `irq_oe` = 0 and `drq_oe` = 0.
- R2: `spec_q` takes `spec_wdata` on the edge where `spec_wr` is high. At every other edge it keeps its value, including edges where `rst` is high.
- R3: A write to the output register with `dor_hold` = 1 sets the sticky reset bit. `core_rst` then stays 1 for as long as that bit is set, and only an output-register write with `dor_hold` = 0 clears it.
- R4: With the sticky bit clear, a data-rate write with `dsr_rst` = 1 drives `core_rst` high for exactly 4 cycles, starting the cycle after the write. The request then clears itself. A data-rate write with `dsr_rst` = 0 has no effect on `core_rst`.
- R5: The sticky bit takes precedence. A self-clearing request that arrives while the sticky bit is set, or in the same cycle the sticky bit is written to 1, is discarded. Setting the sticky bit also cancels a countdown in progress. As a result, `core_rst` falls in the cycle after the sticky bit is written clear.
- R6: `mode` is 2 (AT) when `cfg_ident` = 1, whatever `cfg_mfm` holds. It is 1 (PS/2) when `cfg_ident` = 0 and `cfg_mfm` = 1, and 0 (Model 30) when both are 0. It follows a configuration write in the next cycle.
- R7: In the AT and Model 30 personalities, `irq_oe` and `drq_oe` both equal the DMA-enable bit (`dor_dma` from the last output-register write). In PS/2 both are always 1.
- R8: `tc_evt` shows, one cycle later, `tc_pin` unchanged in AT and Model 30, and `tc_pin` inverted in PS/2.
- R9: `densel_pin` shows, one cycle later, `densel_req` unchanged in AT, and `densel_req` inverted in PS/2 and Model 30.
- R10: The software resets (sticky bit or self-clearing request) leave the configuration, the DMA-enable bit and `spec_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| dor_wr | input | 1 | Output-register write strobe |
| dor_hold | input | 1 | Written value of the sticky reset bit (1 = hold in reset) |
| dor_dma | input | 1 | Written value of the DMA-enable bit |
| dsr_wr | input | 1 | Data-rate register write strobe |
| dsr_rst | input | 1 | Written self-clearing reset request (1 = request) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_ident | input | 1 | Identity select (1 = AT) |
| cfg_mfm | input | 1 | Recording-format select (chooses PS/2 versus Model 30) |
| spec_wr | input | 1 | Specify-parameter write strobe |
| spec_wdata | input | SPEC_W | Specify parameter value |
| tc_pin | input | 1 | Terminal-count pin as seen at the pad |
| densel_req | input | 1 | Core's density-select request, active high |
| core_rst | output | 1 | Reset to the controller core, drive status and FIFO |
| mode | output | 2 | Personality: 0 Model 30, 1 PS/2, 2 AT |
| irq_oe | output | 1 | IRQ pad output enable |
| drq_oe | output | 1 | DRQ pad output enable |
| tc_evt | output | 1 | Terminal count, active high, registered |
| densel_pin | output | 1 | Density-select pad level, registered |
| spec_q | output | SPEC_W | Retained Specify parameters |

## Verification
The hardest case to reach from the ports is the race between the two software resets. A self-clearing request can land while the sticky bit is set, or the sticky bit can be set in the middle of a countdown. If the precedence rule is wrong, `core_rst` stays high for a few extra cycles after the host releases the sticky bit. The directed stimulus creates both orders on purpose and samples `core_rst` in the cycle right after the release. A seeded random loop then sweeps the personality fields, the DMA bit and both pin inputs, and checks the enables and polarities against bench functions.

// File: rtl/dskc_pkg.sv
package dskc_pkg;
  typedef enum logic [1:0] {
    PERS_M30 = 2'd0,
    PERS_PS2 = 2'd1,
    PERS_AT  = 2'd2
  } pers_e;
endpackage

// File: rtl/dskc_rst_ctl.sv
module dskc_rst_ctl #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic dor_wr,
  input  logic dor_hold,
  input  logic dsr_wr,
  input  logic dsr_rst,
  output logic sticky_q,
  output logic dsr_busy,
  output logic core_rst
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;
  logic          sticky_set;

  assign sticky_set = dor_wr && dor_hold;

  // sticky reset bit: set by hardware reset, cleared only by the host
  always_ff @(posedge clk) begin
    if (rst)         sticky_q <= 1'b1;
    else if (dor_wr) sticky_q <= dor_hold;
  end

  // self-clearing request; the sticky bit discards or cancels it
  always_ff @(posedge clk) begin
    if (rst)                          cnt_q <= '0;
    else if (sticky_q || sticky_set)  cnt_q <= '0;
    else if (dsr_wr && dsr_rst)       cnt_q <= HOLD_V;
    else if (cnt_q != '0)             cnt_q <= cnt_q - 1'b1;
  end

  assign dsr_busy = (cnt_q != '0);
  assign core_rst = sticky_q | dsr_busy;
endmodule

// File: rtl/dskc_mode_dec.sv
module dskc_mode_dec
  import dskc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cfg_wr,
  input  logic  cfg_ident,
  input  logic  cfg_mfm,
  input  logic  dor_wr,
  input  logic  dor_dma,
  output pers_e pers,
  output logic  irq_oe,
  output logic  drq_oe,
  output logic  tc_inv,
  output logic  dens_inv
);
  logic ident_q, mfm_q, dma_q;
  logic dma_honoured;

  always_ff @(posedge clk) begin
    if (rst) begin
      ident_q <= 1'b0;
      mfm_q   <= 1'b0;
    end else if (cfg_wr) begin
      ident_q <= cfg_ident;
      mfm_q   <= cfg_mfm;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         dma_q <= 1'b0;
    else if (dor_wr) dma_q <= dor_dma;
  end

  always_comb begin
    if (ident_q)    pers = PERS_AT;
    else if (mfm_q) pers = PERS_PS2;
    else            pers = PERS_M30;
  end

  assign dma_honoured = (pers != PERS_PS2);
  assign irq_oe       = dma_honoured ? dma_q : 1'b1;
  assign drq_oe       = dma_honoured ? dma_q : 1'b1;
  assign tc_inv       = (pers == PERS_PS2);
  assign dens_inv     = (pers != PERS_AT);
endmodule

// File: rtl/dskc_pol_reg.sv
module dskc_pol_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic [W-1:0] inv,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) dout[i] <= 1'b0;
      else     dout[i] <= din[i] ^ inv[i];
    end
  end
endmodule

// File: rtl/dskc_hold_reg.sv
module dskc_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // deliberately without reset: retained across every reset
  always_ff @(posedge clk) begin
    if (we) q <= d;
  end
endmodule

// File: rtl/dskc_rst_mode.sv
module dskc_rst_mode
  import dskc_pkg::*;
#(
  parameter int SPEC_W   = 8,
  parameter int DSR_HOLD = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dor_wr,
  input  logic              dor_hold,
  input  logic              dor_dma,
  input  logic              dsr_wr,
  input  logic              dsr_rst,
  input  logic              cfg_wr,
  input  logic              cfg_ident,
  input  logic              cfg_mfm,
  input  logic              spec_wr,
  input  logic [SPEC_W-1:0] spec_wdata,
  input  logic              tc_pin,
  input  logic              densel_req,
  output logic              core_rst,
  output logic [1:0]        mode,
  output logic              irq_oe,
  output logic              drq_oe,
  output logic              tc_evt,
  output logic              densel_pin,
  output logic [SPEC_W-1:0] spec_q
);
  localparam int PIN_W = 2;

  logic       sticky_w, busy_w;
  pers_e      pers_w;
  logic       tc_inv_w, dens_inv_w;
  logic [PIN_W-1:0] pin_out;

  dskc_rst_ctl #(.HOLD_CYC(DSR_HOLD)) u_rst (
    .clk(clk), .rst(rst),
    .dor_wr(dor_wr), .dor_hold(dor_hold),
    .dsr_wr(dsr_wr), .dsr_rst(dsr_rst),
    .sticky_q(sticky_w), .dsr_busy(busy_w), .core_rst(core_rst)
  );

  dskc_mode_dec u_mode (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_ident(cfg_ident), .cfg_mfm(cfg_mfm),
    .dor_wr(dor_wr), .dor_dma(dor_dma),
    .pers(pers_w), .irq_oe(irq_oe), .drq_oe(drq_oe),
    .tc_inv(tc_inv_w), .dens_inv(dens_inv_w)
  );

  dskc_pol_reg #(.W(PIN_W)) u_pol (
    .clk(clk), .rst(rst),
    .din({densel_req, tc_pin}),
    .inv({dens_inv_w, tc_inv_w}),
    .dout(pin_out)
  );

  dskc_hold_reg #(.W(SPEC_W)) u_spec (
    .clk(clk), .we(spec_wr), .d(spec_wdata), .q(spec_q)
  );

  assign mode       = pers_w;
  assign tc_evt     = pin_out[0];
  assign densel_pin = pin_out[1];
endmodule

// File: rtl/dskc_rst_mode_chk.sv
module dskc_rst_mode_chk #(
  parameter int SPEC_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              dor_wr,
  input logic              dor_hold,
  input logic              dsr_wr,
  input logic              dsr_rst,
  input logic              spec_wr,
  input logic [SPEC_W-1:0] spec_q,
  input logic              core_rst,
  input logic [1:0]        mode,
  input logic              irq_oe,
  input logic              drq_oe,
  input logic              sticky_q,
  input logic              dsr_busy
);
  // R1
  hw_entry_chk: assert property (@(posedge clk)
    $past(rst) && !rst |-> core_rst && !irq_oe && !drq_oe && mode == 2'd0);

  // R2
  spec_keep_chk: assert property (@(posedge clk)
    !spec_wr |=> $stable(spec_q));

  // R3
  sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
    dor_wr && dor_hold |=> core_rst && sticky_q);

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sticky_q && !dor_wr |=> core_rst);

  // R5
  sticky_wins_chk: assert property (@(posedge clk) disable iff (rst)
    sticky_q && dor_wr && !dor_hold |=> !core_rst);

  // R4
  dsr_start_chk: assert property (@(posedge clk) disable iff (rst)
    !sticky_q && !dor_wr && dsr_wr && dsr_rst |=> core_rst && dsr_busy);

  // R4
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !core_rst && !dor_wr && !(dsr_wr && dsr_rst) |=> !core_rst);

  // R7
  ps2_drive_chk: assert property (@(posedge clk) disable iff (rst)
    mode == 2'd1 |-> irq_oe && drq_oe);

  // R6
  mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    mode != 2'd3);
endmodule

bind dskc_rst_mode dskc_rst_mode_chk #(.SPEC_W(SPEC_W)) u_chk (
  .clk(clk), .rst(rst), .dor_wr(dor_wr), .dor_hold(dor_hold),
  .dsr_wr(dsr_wr), .dsr_rst(dsr_rst), .spec_wr(spec_wr), .spec_q(spec_q),
  .core_rst(core_rst), .mode(mode), .irq_oe(irq_oe), .drq_oe(drq_oe),
  .sticky_q(sticky_w), .dsr_busy(busy_w)
);

// File: tb/test_dskc_rst_mode.sv
module test_dskc_rst_mode;
  localparam int CLK_PER = 10;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dor_wr = 0, dor_hold = 0, dor_dma = 0;
  logic dsr_wr = 0, dsr_rst = 0;
  logic cfg_wr = 0, cfg_ident = 0, cfg_mfm = 0;
  logic spec_wr = 0;
  logic [SW-1:0] spec_wdata = '0;
  logic tc_pin = 0, densel_req = 0;
  logic core_rst, irq_oe, drq_oe, tc_evt, densel_pin;
  logic [1:0] mode;
  logic [SW-1:0] spec_q;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  dskc_rst_mode #(.SPEC_W(SW), .DSR_HOLD(4)) i_dskc_rst_mode (
    .clk(clk), .rst(rst), .dor_wr(dor_wr), .dor_hold(dor_hold), .dor_dma(dor_dma),
    .dsr_wr(dsr_wr), .dsr_rst(dsr_rst), .cfg_wr(cfg_wr), .cfg_ident(cfg_ident),
    .cfg_mfm(cfg_mfm), .spec_wr(spec_wr), .spec_wdata(spec_wdata),
    .tc_pin(tc_pin), .densel_req(densel_req), .core_rst(core_rst), .mode(mode),
    .irq_oe(irq_oe), .drq_oe(drq_oe), .tc_evt(tc_evt), .densel_pin(densel_pin),
    .spec_q(spec_q)
  );

  function automatic logic [1:0] exp_mode(logic id, logic mf);
    return id ? 2'd2 : (mf ? 2'd1 : 2'd0);
  endfunction
  function automatic logic exp_oe(logic [1:0] m, logic dma);
    return (m == 2'd1) ? 1'b1 : dma;
  endfunction
  function automatic logic exp_tc(logic [1:0] m, logic p);
    return (m == 2'd1) ? ~p : p;
  endfunction
  function automatic logic exp_dens(logic [1:0] m, logic r);
    return (m == 2'd2) ? r : ~r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_dor(logic h, logic d);
    dor_wr = 1; dor_hold = h; dor_dma = d; step(); dor_wr = 0;
  endtask
  task automatic wr_dsr(logic r);
    dsr_wr = 1; dsr_rst = r; step(); dsr_wr = 0;
  endtask
  task automatic wr_cfg(logic id, logic mf);
    cfg_wr = 1; cfg_ident = id; cfg_mfm = mf; step(); cfg_wr = 0;
  endtask
  task automatic wr_spec(logic [SW-1:0] v);
    spec_wr = 1; spec_wdata = v; step(); spec_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    wr_spec(8'hA5);
    rst = 1; step(); step(); rst = 0;
    // R1 reset state
    check("R1 core_rst", core_rst, 1);
    check("R1 mode", mode, 0);
    check("R1 irq_oe", irq_oe, 0);
    check("R1 drq_oe", drq_oe, 0);
    check("R2 spec kept over reset", spec_q, 8'hA5);
    // R3 sticky
    repeat (6) step();
    check("R3 sticky holds", core_rst, 1);
    // R5 request during sticky is discarded
    wr_dsr(1);
    check("R3 still held", core_rst, 1);
    wr_dor(0, 0);
    check("R5 release after sticky clear", core_rst, 0);
    // R4 four-cycle pulse
    wr_dsr(1);
    for (int i = 0; i < 4; i++) check("R4 pulse high", core_rst, 1);
    for (int i = 0; i < 3; i++) begin
      check("R4 pulse high", core_rst, 1);
      step();
    end
    check("R4 pulse last", core_rst, 1);
    step();
    check("R4 self clear", core_rst, 0);
    wr_dsr(0);
    check("R4 zero request ignored", core_rst, 0);
    // R5 sticky set during countdown cancels it
    wr_dsr(1);
    wr_dor(1, 0);
    check("R3 sticky set", core_rst, 1);
    wr_dor(0, 0);
    check("R5 countdown cancelled", core_rst, 0);
    // R5 request in same cycle as sticky set
    dsr_wr = 1; dsr_rst = 1; dor_wr = 1; dor_hold = 1; dor_dma = 0;
    step(); dsr_wr = 0; dor_wr = 0;
    wr_dor(0, 0);
    check("R5 same-cycle request dropped", core_rst, 0);
    // R2 write
    wr_spec(8'h3C);
    check("R2 spec write", spec_q, 8'h3C);
    // R6 / R7
    wr_cfg(1, 0);
    check("R6 AT", mode, 2);
    wr_dor(0, 1);
    check("R7 AT dma on", irq_oe, 1);
    wr_dor(0, 0);
    check("R7 AT dma off irq", irq_oe, 0);
    check("R7 AT dma off drq", drq_oe, 0);
    wr_cfg(1, 1);
    check("R6 AT mfm ignored", mode, 2);
    wr_cfg(0, 1);
    check("R6 PS2", mode, 1);
    check("R7 PS2 driven", drq_oe, 1);
    // R10 soft resets keep config
    wr_dor(0, 1);
    wr_dsr(1);
    repeat (5) step();
    check("R10 mode kept", mode, 1);
    check("R10 spec kept", spec_q, 8'h3C);
    wr_cfg(0, 0);
    check("R6 M30", mode, 0);
    wr_dor(1, 1);
    wr_dor(0, 1);
    check("R10 dma kept", irq_oe, 1);
    // R1 second hardware reset
    rst = 1; step(); rst = 0;
    check("R1 mode cleared", mode, 0);
    check("R1 dma cleared", irq_oe, 0);
    check("R2 spec kept", spec_q, 8'h3C);
    wr_dor(0, 0);
    // random sweep
    for (int n = 0; n < 300; n++) begin
      logic id, mf, dm, tp, dr;
      logic [1:0] em;
      id = 1'($urandom); mf = 1'($urandom); dm = 1'($urandom);
      tp = 1'($urandom); dr = 1'($urandom);
      em = exp_mode(id, mf);
      wr_cfg(id, mf);
      wr_dor(0, dm);
      tc_pin = tp; densel_req = dr;
      step();
      check("R6 rand mode", mode, em);
      check("R7 rand irq", irq_oe, exp_oe(em, dm));
      check("R7 rand drq", drq_oe, exp_oe(em, dm));
      check("R8 rand tc", tc_evt, exp_tc(em, tp));
      check("R9 rand densel", densel_pin, exp_dens(em, dr));
      check("R4 no reset", core_rst, 0);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule